// File: doc/BRIEF.md
# Programmable Flag Offset Register Port

This block holds the two programmable flag thresholds of a synchronous FIFO: the almost-empty offset and the almost-full offset. Software or a controller reaches both through the ordinary FIFO data pins. An active-low load strobe switches the write and read enables from moving data to stepping through the two offset registers. While the strobe is low, each write-enabled edge of the write clock stores the input word into the next register. Each read-enabled edge of the read clock copies the next register onto the 12-bit output bus. The order is always the empty offset first, then the full offset, and the sequence wraps back to the start.

Raising the strobe returns the pins to normal data traffic and rewinds both sequence pointers to the empty offset. Readback is allowed only in standard mode. In first-word-fall-through mode the read side of the sequence is inert. The stored offsets are presented continuously to the flag comparators, which lie outside this block along with the FIFO memory. The offsets are log2(DEPTH) bits wide. After reset each one takes a default that depends on the FIFO depth.

Top module: `fifo_ofs_port`

## Requirements
- R1: The reset state, with rst high on a clock edge, sets both offsets to the depth default. That default is 31 for DEPTH up to 256, 63 for DEPTH up to 512, and 127 for larger depths. Reset also clears dout to zero and points both sequences at the empty offset.
- R2: When load_n and wen_n are both low at a wr_clk rising edge, din[AW-1:0] is stored into the register the write pointer selects, with AW = log2(DEPTH). The first such write after a rewind goes to the empty offset and the second goes to the full offset.
- R3: After writing the full offset, the write pointer wraps, so the next write lands in the empty offset again.
- R4: While load_n is high, wen_n has no effect on either offset, and the write pointer rewinds to the empty offset.
- R5: In standard mode (fwft_mode = 0), when load_n and ren_n are both low at a rd_clk rising edge, dout takes the selected offset zero-extended to 12 bits. The selection alternates between the empty offset and the full offset, starting with the empty offset and wrapping.
- R6: While load_n is high at a rd_clk edge, the read pointer rewinds to the empty offset, and dout is not changed.
- R7: In first-word-fall-through mode (fwft_mode = 1), a read-enabled edge with load_n low leaves dout unchanged and does not advance the read pointer.
- R8: Bits of din at or above AW are discarded on a write, and dout bits at or above AW always read as zero.
- R9: With load_n low and wen_n high, a wr_clk edge changes neither offset nor the write pointer.
- R10: The empty_ofs and full_ofs outputs equal the stored offsets from the edge after each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| load_n | input | 1 | Active-low offset access strobe |
| wen_n | input | 1 | Active-low write enable |
| ren_n | input | 1 | Active-low read enable |
| fwft_mode | input | 1 | 1 = first-word-fall-through mode, where readback is disabled |
| din | input | 12 | Write data bus |
| dout | output | 12 | Offset readback bus |
| empty_ofs | output | AW | Almost-empty offset to the flag logic |
| full_ofs | output | AW | Almost-full offset to the flag logic |

## Verification
The assertions assume that load_n, wen_n, ren_n and fwft_mode are already settled when each clock edge samples them. They also assume that the offsets do not change in the write domain during a read-domain readback. The bench meets both assumptions: it drives every input on a falling clock edge, and it keeps offset writes and readbacks in separate phases. Each time it raises the strobe, it holds it high for two write-clock periods, so the read clock samples the high level as well.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  // Reset value of both offsets for a given FIFO depth
  function automatic int dflt_ofs(input int depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

  function automatic ofs_sel_e next_sel(input ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OW    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_n,
  input  logic                       wen_n,
  input  logic [OW-1:0]              din,
  output logic [$clog2(DEPTH)-1:0]   empty_q,
  output logic [$clog2(DEPTH)-1:0]   full_q
);
  localparam int AW  = $clog2(DEPTH);
  localparam int DEF = dflt_ofs(DEPTH);
  localparam logic [AW-1:0] DEF_V = DEF[AW-1:0];

  ofs_sel_e          sel_q;
  logic   [AW-1:0]   wdata;

  assign wdata = din[AW-1:0];

  generate
    if (AW < OW) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^din[OW-1:AW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= DEF_V;
      full_q  <= DEF_V;
      sel_q   <= SEL_EMPTY;
    end else if (load_n) begin
      sel_q <= SEL_EMPTY;
    end else if (!wen_n) begin
      if (sel_q == SEL_EMPTY) empty_q <= wdata;
      else                    full_q  <= wdata;
      sel_q <= next_sel(sel_q);
    end
  end

  a_r2_empty_write: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wen_n && sel_q == SEL_EMPTY) |=> (empty_q == $past(din[AW-1:0])));

  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wen_n && sel_q == SEL_FULL) |=> (full_q == $past(din[AW-1:0])));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wen_n && sel_q == SEL_FULL) |=> (sel_q == SEL_EMPTY));

  a_r4_load_high_hold: assert property (@(posedge clk) disable iff (rst)
    load_n |=> ($stable(empty_q) && $stable(full_q) && sel_q == SEL_EMPTY));

  a_r9_no_enable: assert property (@(posedge clk) disable iff (rst)
    (!load_n && wen_n) |=> ($stable(empty_q) && $stable(full_q) && $stable(sel_q)));

endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OW    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_n,
  input  logic                       ren_n,
  input  logic                       fwft_mode,
  input  logic [$clog2(DEPTH)-1:0]   empty_ofs,
  input  logic [$clog2(DEPTH)-1:0]   full_ofs,
  output logic [OW-1:0]              dout
);
  localparam int AW = $clog2(DEPTH);

  ofs_sel_e        sel_q;
  logic            rb_go;
  logic [AW-1:0]   pick;

  assign rb_go = !load_n && !ren_n && !fwft_mode;
  assign pick  = (sel_q == SEL_EMPTY) ? empty_ofs : full_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      sel_q <= SEL_EMPTY;
    end else if (load_n) begin
      sel_q <= SEL_EMPTY;
    end else if (rb_go) begin
      dout  <= OW'(pick);
      sel_q <= next_sel(sel_q);
    end
  end

  a_r5_first_empty: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !ren_n && !fwft_mode && sel_q == SEL_EMPTY)
      |=> (dout == OW'($past(empty_ofs))));

  a_r5_then_full: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !ren_n && !fwft_mode && sel_q == SEL_FULL)
      |=> (dout == OW'($past(full_ofs)) && sel_q == SEL_EMPTY));

  a_r6_rewind: assert property (@(posedge clk) disable iff (rst)
    load_n |=> (sel_q == SEL_EMPTY && $stable(dout)));

  a_r7_fwft_inert: assert property (@(posedge clk) disable iff (rst)
    (fwft_mode && !ren_n) |=> ($stable(dout) && $stable(sel_q)));

  generate
    if (AW < OW) begin : g_hi_chk
      a_r8_hi_zero: assert property (@(posedge clk) disable iff (rst)
        dout[OW-1:AW] == '0);
    end
  endgenerate

endmodule

// File: rtl/fifo_ofs_port.sv
module fifo_ofs_port
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OW    = 12
) (
  input  logic                       wr_clk,
  input  logic                       rd_clk,
  input  logic                       rst,
  input  logic                       load_n,
  input  logic                       wen_n,
  input  logic                       ren_n,
  input  logic                       fwft_mode,
  input  logic [OW-1:0]              din,
  output logic [OW-1:0]              dout,
  output logic [$clog2(DEPTH)-1:0]   empty_ofs,
  output logic [$clog2(DEPTH)-1:0]   full_ofs
);

  ofs_wr_seq #(.DEPTH(DEPTH), .OW(OW)) u_wr (
    .clk     (wr_clk),
    .rst     (rst),
    .load_n  (load_n),
    .wen_n   (wen_n),
    .din     (din),
    .empty_q (empty_ofs),
    .full_q  (full_ofs)
  );

  ofs_rd_seq #(.DEPTH(DEPTH), .OW(OW)) u_rd (
    .clk       (rd_clk),
    .rst       (rst),
    .load_n    (load_n),
    .ren_n     (ren_n),
    .fwft_mode (fwft_mode),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .dout      (dout)
  );

endmodule

// File: tb/test_fifo_ofs_port.sv
module test_fifo_ofs_port;
  localparam int DEPTH = 256;
  localparam int OW    = 12;
  localparam int AW    = 8;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst = 1'b1, load_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1, fwft_mode = 1'b0;
  logic [OW-1:0] din = '0;
  logic [OW-1:0] dout;
  logic [AW-1:0] empty_ofs, full_ofs;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_e, m_f;
  logic [OW-1:0] m_dout;
  bit m_wp, m_rp;
  bit done = 0;

  always #10 wr_clk = ~wr_clk;
  initial begin #5; forever #10 rd_clk = ~rd_clk; end

  fifo_ofs_port #(.DEPTH(DEPTH), .OW(OW)) i_fifo_ofs_port (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .load_n(load_n),
    .wen_n(wen_n), .ren_n(ren_n), .fwft_mode(fwft_mode), .din(din),
    .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ofs(input string tag);
    chk(empty_ofs == m_e, {tag, " empty"}, empty_ofs, m_e);
    chk(full_ofs == m_f, {tag, " full"}, full_ofs, m_f);
  endtask

  task automatic wr_op(input logic [OW-1:0] d);
    @(negedge wr_clk); load_n = 1'b0; wen_n = 1'b0; din = d;
    @(negedge wr_clk); wen_n = 1'b1;
    if (m_wp) m_f = d[AW-1:0]; else m_e = d[AW-1:0];
    m_wp = !m_wp;
  endtask

  task automatic rd_op();
    @(negedge rd_clk); load_n = 1'b0; ren_n = 1'b0;
    @(negedge rd_clk); ren_n = 1'b1;
    if (!fwft_mode) begin
      m_dout = OW'(m_rp ? m_f : m_e);
      m_rp = !m_rp;
    end
  endtask

  task automatic release_load(input bit with_wen);
    @(negedge wr_clk); load_n = 1'b1; wen_n = !with_wen; din = 12'hF5A;
    @(negedge wr_clk);
    @(negedge wr_clk); wen_n = 1'b1;
    m_wp = 0; m_rp = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    rst = 1'b0;
    m_e = 8'd31; m_f = 8'd31; m_dout = '0; m_wp = 0; m_rp = 0;
    @(negedge rd_clk);
    // R1 reset defaults
    chk_ofs("R1 reset");
    chk(dout == 0, "R1 dout reset", dout, 0);

    // R2 R3 R10: sweep of writes with periodic rewinds
    for (int i = 0; i < 60; i++) begin
      wr_op(12'((i * 37 + 11) % 4096));
      chk_ofs("R2 R3 R10 write");
      if (i % 7 == 6) begin
        release_load(1);
        chk_ofs("R4 load high ignores wen");
      end
    end

    // R4: after a rewind the first write lands in the empty offset
    release_load(0);
    wr_op(12'h013);
    chk(empty_ofs == 8'h13, "R4 rewind to empty", empty_ofs, 8'h13);
    chk_ofs("R4 model");

    // R9: load low, wen high
    @(negedge wr_clk); load_n = 1'b0; wen_n = 1'b1; din = 12'h0EE;
    @(negedge wr_clk);
    @(negedge wr_clk);
    chk_ofs("R9 no enable");
    wr_op(12'h0C4);
    chk(full_ofs == 8'hC4, "R9 pointer held (full next)", full_ofs, 8'hC4);

    // R8 high bits dropped on write
    release_load(0);
    wr_op(12'hFAB);
    wr_op(12'h9D2);
    chk(empty_ofs == 8'hAB, "R8 truncate empty", empty_ofs, 8'hAB);
    chk(full_ofs == 8'hD2, "R8 truncate full", full_ofs, 8'hD2);

    // R5 readback sequence with wrap, R8 zero high bits
    release_load(0);
    for (int k = 0; k < 5; k++) begin
      rd_op();
      chk(dout == m_dout, "R5 readback order", dout, m_dout);
      chk(dout[OW-1:AW] == 0, "R8 high bits zero", dout[OW-1:AW], 0);
    end

    // R6 rewind of read pointer
    release_load(0);
    chk(dout == m_dout, "R6 dout held under load high", dout, m_dout);
    rd_op();
    chk(dout == 12'h0AB, "R6 readback restarts at empty", dout, 12'h0AB);

    // R7 fwft: readback inert, pointer unmoved
    fwft_mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      rd_op();
      chk(dout == 12'h0AB, "R7 fwft dout unchanged", dout, 12'h0AB);
    end
    fwft_mode = 1'b0;
    rd_op();
    chk(dout == 12'h0D2, "R7 fwft pointer unmoved", dout, 12'h0D2);

    // Sweep of write then readback pairs
    for (int v = 0; v < 40; v++) begin
      release_load(0);
      wr_op(12'((v * 101 + 7) % 4096));
      wr_op(12'((v * 53 + 200) % 4096));
      release_load(0);
      rd_op();
      chk(dout == m_dout, "R5 sweep empty", dout, m_dout);
      rd_op();
      chk(dout == m_dout, "R5 sweep full", dout, m_dout);
    end

    // R1 again: reset restores defaults mid-sequence
    @(negedge wr_clk); rst = 1'b1;
    @(negedge wr_clk); @(negedge wr_clk); rst = 1'b0;
    @(negedge rd_clk);
    m_e = 8'd31; m_f = 8'd31; m_wp = 0; m_rp = 0;
    chk_ofs("R1 re-reset");
    chk(dout == 0, "R1 dout re-reset", dout, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule